// File: doc/BRIEF.md
# Byte/Word Arithmetic, Logic and Shift Unit

This unit computes arithmetic, logic and shift results on 8-bit or 16-bit operands for an execution datapath. A mode input picks between an arithmetic/logic set and a shift/rotate set, and a 3-bit code picks the operation inside that set. A combinational path returns the result, a six-bit flags vector and a write-enable in the same cycle. The write-enable tells the register stage whether the result is stored or only the flags are kept.

A second, registered path runs shifts whose repeat count comes from a count register. The caller pulses `start` with the operand, the code, the width and the count. The unit then repeats the selected one-bit step once per count value and pulses `var_done` with the final result and flags. The two paths are independent, so single-cycle operations keep flowing while a multi-cycle shift is in progress.

Top module: `alu_shift_unit`

## Requirements
- R1: With `shift_mode`=0, `op_sel` codes 0..7 select ADD, OR, ADC, SBB, AND, SUB, XOR, CMP. ADC adds `carry_in`, SBB subtracts it, and CMP subtracts like SUB. For these ops CF is the carry (or borrow) out of the sign bit and OF is signed overflow.
- R2: OR, AND and XOR clear CF, OF and AF.
- R3: `flags` bit 0 is CF, bit 1 PF (1 when the low result byte has an even count of ones), bit 2 AF (carry/borrow out of bit 3 for arithmetic, 0 for logic and shifts), bit 3 ZF, bit 4 SF and bit 5 OF.
- R4: With `sx_imm`=1, `opb[7:0]` is sign-extended to 16 bits before use, so FF becomes FFFF.
- R5: With `is_word`=0, only bits 7:0 of the operands take part. The sign is bit 7, carry is taken out of bit 7, and `res[15:8]` is 0.
- R6: CMP always drives `wr_en` low. `flags_only`=1 (used for TEST with AND) also drives `wr_en` low. In both cases `flags` still reflects the operation. Every other operation drives `wr_en` high.
- R7: With `shift_mode`=1, the codes are 0 ROL, 1 ROR, 2 RCL, 3 RCR, 4 SHL, 5 SHR and 7 SAR, each a one-bit step on `opa`. Even codes shift left and set CF from the old sign bit. Odd codes shift right and set CF from the old bit 0.
- R8: Shift code 6 returns all ones (00FF for a byte, FFFF for a word). It takes CF from the old sign bit, as a left shift does.
- R9: `start` with `busy` low latches the operand, code, width, carry and `count`, and raises `busy`. After one setup cycle and then one cycle per count step, `var_done` pulses for one cycle with `busy` low. `var_res` and `var_flags` then equal the selected one-bit step applied `count` times, with RCL/RCR carrying through CF.
- R10: A zero `count` returns the operand unchanged on `var_res`, with CF equal to the latched `carry_in`, OF and AF 0, and ZF, SF and PF taken from the operand. `var_done` appears two cycles after the start edge.
- R11: `start` while `busy` is high is ignored, and the running shift finishes with its own data.
- R12: The combinational path gives correct results in every cycle while a variable shift is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_mode | input | 1 | 0 arithmetic/logic set, 1 shift/rotate set |
| op_sel | input | 3 | Operation code within the set |
| is_word | input | 1 | 1 word, 0 byte |
| sx_imm | input | 1 | Sign-extend opb[7:0] |
| carry_in | input | 1 | Carry input |
| flags_only | input | 1 | Keep flags, suppress write |
| opa | input | 16 | First operand / shift operand |
| opb | input | 16 | Second operand |
| start | input | 1 | Begin variable shift |
| count | input | CNT_W | Variable shift repeat count |
| res | output | 16 | Combinational result |
| flags | output | 6 | Combinational flags |
| wr_en | output | 1 | Result should be written |
| busy | output | 1 | Variable shift in progress |
| var_done | output | 1 | One-cycle completion pulse |
| var_res | output | 16 | Variable shift result |
| var_flags | output | 6 | Variable shift flags |

## Verification
The single-cycle path and the variable shift can be active in the same cycle. The bench drives a fresh random single-cycle operation on every cycle of a variable shift and checks it against its own model. It also checks that the shift's result and flags are not disturbed. In the same runs it presents a second `start` with different data while `busy` is high. The completion cycle must match the first request's count, and the final value must match the first operand.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DW = 16;
    localparam int BW = DW / 2;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef enum logic [2:0] {
        A_ADD = 3'd0, A_OR = 3'd1, A_ADC = 3'd2, A_SBB = 3'd3,
        A_AND = 3'd4, A_SUB = 3'd5, A_XOR = 3'd6, A_CMP = 3'd7
    } arith_e;

    typedef enum logic [2:0] {
        S_ROL = 3'd0, S_ROR = 3'd1, S_RCL = 3'd2, S_RCR = 3'd3,
        S_SHL = 3'd4, S_SHR = 3'd5, S_ONES = 3'd6, S_SAR = 3'd7
    } shift_e;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic word);
        return word ? v : {{BW{1'b0}}, v[BW-1:0]};
    endfunction

    function automatic logic top_bit(input logic [DW-1:0] v, input logic word);
        return word ? v[DW-1] : v[BW-1];
    endfunction

    function automatic flags_t mkflags(input logic [DW-1:0] r, input logic word,
                                       input logic cf, input logic of, input logic af);
        flags_t f;
        f.cf = cf;
        f.of = of;
        f.af = af;
        f.pf = ~^r[7:0];
        f.sf = top_bit(r, word);
        f.zf = (fit(r, word) == '0);
        return f;
    endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
(
    input  logic [2:0]    code_i,
    input  logic          word_i,
    input  logic          sx_i,
    input  logic          cin_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output flags_t        flags_o
);
    logic [DW-1:0] b_ext, am, bm, r;
    logic [DW:0]   ext;
    logic          is_sub, use_c, c, co, of, af, sa, sb, sr;

    always_comb begin
        b_ext  = sx_i ? {{BW{b_i[BW-1]}}, b_i[BW-1:0]} : b_i;
        am     = fit(a_i, word_i);
        bm     = fit(b_ext, word_i);
        is_sub = (code_i == A_SBB) || (code_i == A_SUB) || (code_i == A_CMP);
        use_c  = (code_i == A_ADC) || (code_i == A_SBB);
        c      = use_c & cin_i;
        if (is_sub)
            ext = {1'b0, am} - {1'b0, bm} - {{DW{1'b0}}, c};
        else
            ext = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, c};
        sa = top_bit(am, word_i);
        sb = top_bit(bm, word_i);
        co = word_i ? ext[DW] : ext[BW];
        r  = '0;
        of = 1'b0;
        af = 1'b0;
        case (code_i)
            A_OR:  r = am | bm;
            A_AND: r = am & bm;
            A_XOR: r = am ^ bm;
            default: begin
                r  = fit(ext[DW-1:0], word_i);
                sr = top_bit(r, word_i);
                of = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
                af = am[4] ^ bm[4] ^ r[4];
            end
        endcase
        sr = top_bit(r, word_i);
        res_o = r;
        if ((code_i == A_OR) || (code_i == A_AND) || (code_i == A_XOR))
            flags_o = mkflags(r, word_i, 1'b0, 1'b0, 1'b0);
        else
            flags_o = mkflags(r, word_i, co, of, af);
    end
endmodule

// File: rtl/alu_shift_step.sv
module alu_shift_step
    import alu_pkg::*;
(
    input  logic [2:0]    code_i,
    input  logic          word_i,
    input  logic          cin_i,
    input  logic [DW-1:0] val_i,
    output logic [DW-1:0] res_o,
    output flags_t        flags_o
);
    logic [DW-1:0] xm, lres, rres, r;
    logic          msb, lin, fill, cf, of, rmsb, rnext;

    always_comb begin
        xm  = fit(val_i, word_i);
        msb = top_bit(xm, word_i);
        case (code_i)
            S_ROL:   lin = msb;
            S_RCL:   lin = cin_i;
            S_ONES:  lin = 1'b1;
            default: lin = 1'b0;
        endcase
        case (code_i)
            S_ROR:   fill = xm[0];
            S_RCR:   fill = cin_i;
            S_SAR:   fill = msb;
            default: fill = 1'b0;
        endcase
        lres = fit({xm[DW-2:0], lin}, word_i);
        if (code_i == S_ONES)
            lres = fit('1, word_i);
        rres = word_i ? {fill, xm[DW-1:1]} : {{BW{1'b0}}, fill, xm[BW-1:1]};
        if (!code_i[0]) begin
            r  = lres;
            cf = msb;
            of = top_bit(r, word_i) ^ msb;
        end else begin
            r     = rres;
            cf    = xm[0];
            rmsb  = top_bit(r, word_i);
            rnext = word_i ? r[DW-2] : r[BW-2];
            case (code_i)
                S_SHR:   of = msb;
                S_SAR:   of = 1'b0;
                default: of = rmsb ^ rnext;
            endcase
        end
        res_o   = r;
        flags_o = mkflags(r, word_i, cf, of, 1'b0);
    end
endmodule

// File: rtl/alu_shift_seq.sv
module alu_shift_seq
    import alu_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       code_i,
    input  logic             word_i,
    input  logic             cin_i,
    input  logic [DW-1:0]    opd_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DW-1:0]    res_o,
    output flags_t           flags_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} st_e;

    typedef struct packed {
        st_e              st;
        logic [DW-1:0]    val;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       code;
        logic             word;
        flags_t           fl;
        logic             done;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [DW-1:0] step_r;
    flags_t        step_f;

    alu_shift_step u_step (
        .code_i  (seq_q.code),
        .word_i  (seq_q.word),
        .cin_i   (seq_q.fl.cf),
        .val_i   (seq_q.val),
        .res_o   (step_r),
        .flags_o (step_f)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st   = ST_SETUP;
                    seq_d.val  = fit(opd_i, word_i);
                    seq_d.cnt  = cnt_i;
                    seq_d.code = code_i;
                    seq_d.word = word_i;
                    seq_d.fl   = mkflags(fit(opd_i, word_i), word_i, cin_i, 1'b0, 1'b0);
                end
            end
            ST_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.st = ST_RUN;
                end
            end
            default: begin
                seq_d.val = step_r;
                seq_d.fl  = step_f;
                seq_d.cnt = seq_q.cnt - CNT_W'(1);
                if (seq_q.cnt == CNT_W'(1)) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o  = (seq_q.st != ST_IDLE);
    assign done_o  = seq_q.done;
    assign res_o   = seq_q.val;
    assign flags_o = seq_q.fl;
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_mode,
    input  logic [2:0]       op_sel,
    input  logic             is_word,
    input  logic             sx_imm,
    input  logic             carry_in,
    input  logic             flags_only,
    input  logic [15:0]      opa,
    input  logic [15:0]      opb,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic [15:0]      res,
    output logic [5:0]       flags,
    output logic             wr_en,
    output logic             busy,
    output logic             var_done,
    output logic [15:0]      var_res,
    output logic [5:0]       var_flags
);
    logic [DW-1:0] ar_r, sh_r;
    flags_t        ar_f, sh_f, vr_f;

    alu_arith u_arith (
        .code_i  (op_sel),
        .word_i  (is_word),
        .sx_i    (sx_imm),
        .cin_i   (carry_in),
        .a_i     (opa),
        .b_i     (opb),
        .res_o   (ar_r),
        .flags_o (ar_f)
    );

    alu_shift_step u_shift1 (
        .code_i  (op_sel),
        .word_i  (is_word),
        .cin_i   (carry_in),
        .val_i   (opa),
        .res_o   (sh_r),
        .flags_o (sh_f)
    );

    alu_shift_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .code_i  (op_sel),
        .word_i  (is_word),
        .cin_i   (carry_in),
        .opd_i   (opa),
        .cnt_i   (count),
        .busy_o  (busy),
        .done_o  (var_done),
        .res_o   (var_res),
        .flags_o (vr_f)
    );

    always_comb begin
        if (shift_mode) begin
            res   = sh_r;
            flags = sh_f;
            wr_en = ~flags_only;
        end else begin
            res   = ar_r;
            flags = ar_f;
            wr_en = ~flags_only & (op_sel != A_CMP);
        end
    end

    assign var_flags = vr_f;
endmodule

// File: rtl/alu_shift_unit_chk.sv
module alu_shift_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        shift_mode,
    input logic [2:0]  op_sel,
    input logic        is_word,
    input logic        start,
    input logic [15:0] res,
    input logic        wr_en,
    input logic        busy,
    input logic        var_done
);
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_mode && op_sel == 3'd7) |-> !wr_en); // R6
    AST_ONES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mode && op_sel == 3'd6) |-> (res == (is_word ? 16'hFFFF : 16'h00FF))); // R8
    AST_BYTE_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !is_word |-> (res[15:8] == 8'h00)); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        var_done |=> !var_done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        var_done |-> !busy); // R9
endmodule

bind alu_shift_unit alu_shift_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_mode (shift_mode),
    .op_sel     (op_sel),
    .is_word    (is_word),
    .start      (start),
    .res        (res),
    .wr_en      (wr_en),
    .busy       (busy),
    .var_done   (var_done)
);

// File: tb/tb_alu_shift_unit.sv
`timescale 1ns/1ps
module tb_alu_shift_unit;
    localparam int CW = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic shift_mode = 0, is_word = 0, sx_imm = 0, carry_in = 0, flags_only = 0, start = 0;
    logic [2:0] op_sel = '0;
    logic [15:0] opa = '0, opb = '0;
    logic [CW-1:0] count = '0;
    logic [15:0] res, var_res;
    logic [5:0] flags, var_flags;
    logic wr_en, busy, var_done;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    alu_shift_unit #(.CNT_W(CW)) dut (.*);

    function automatic logic [15:0] msk(input logic [15:0] v, input logic w);
        return w ? v : {8'h00, v[7:0]};
    endfunction

    function automatic logic [5:0] mkf(input logic [15:0] r, input logic w,
                                       input logic cf, input logic of, input logic af);
        logic [15:0] m;
        m = msk(r, w);
        return {of, (w ? m[15] : m[7]), (m == 16'h0), af, ~^m[7:0], cf};
    endfunction

    // returns {flags, result}
    function automatic logic [21:0] m_arith(input logic [2:0] op, input logic w, input logic sx,
                                            input logic c, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] bb, am, bm, r;
        logic [16:0] s;
        logic cy, sa, sb, sr, ov;
        bb = sx ? {{8{b[7]}}, b[7:0]} : b;
        am = msk(a, w); bm = msk(bb, w);
        sa = w ? am[15] : am[7]; sb = w ? bm[15] : bm[7];
        case (op)
            3'd1: return {mkf(am | bm, w, 0, 0, 0), am | bm};
            3'd4: return {mkf(am & bm, w, 0, 0, 0), am & bm};
            3'd6: return {mkf(am ^ bm, w, 0, 0, 0), am ^ bm};
            3'd0: s = {1'b0, am} + {1'b0, bm};
            3'd2: s = {1'b0, am} + {1'b0, bm} + 17'(c);
            3'd3: s = {1'b0, am} - {1'b0, bm} - 17'(c);
            default: s = {1'b0, am} - {1'b0, bm};
        endcase
        r  = msk(s[15:0], w);
        cy = w ? s[16] : s[8];
        sr = w ? r[15] : r[7];
        if (op == 3'd0 || op == 3'd2) ov = (sa == sb) && (sr != sa);
        else                          ov = (sa != sb) && (sr != sa);
        return {mkf(r, w, cy, ov, am[4] ^ bm[4] ^ r[4]), r};
    endfunction

    function automatic logic [21:0] m_step(input logic [2:0] op, input logic w, input logic c,
                                           input logic [15:0] x);
        logic [15:0] xm, r;
        logic t, cf, of, rt, rn;
        xm = msk(x, w);
        t = w ? xm[15] : xm[7];
        case (op)
            3'd0: r = w ? {xm[14:0], t} : {8'h0, xm[6:0], t};
            3'd2: r = w ? {xm[14:0], c} : {8'h0, xm[6:0], c};
            3'd4: r = w ? {xm[14:0], 1'b0} : {8'h0, xm[6:0], 1'b0};
            3'd6: r = w ? 16'hFFFF : 16'h00FF;
            3'd1: r = w ? {xm[0], xm[15:1]} : {8'h0, xm[0], xm[7:1]};
            3'd3: r = w ? {c, xm[15:1]} : {8'h0, c, xm[7:1]};
            3'd5: r = w ? {1'b0, xm[15:1]} : {8'h0, 1'b0, xm[7:1]};
            default: r = w ? {t, xm[15:1]} : {8'h0, t, xm[7:1]};
        endcase
        rt = w ? r[15] : r[7];
        rn = w ? r[14] : r[6];
        if (!op[0]) begin cf = t; of = rt ^ t; end
        else begin
            cf = xm[0];
            of = (op == 3'd5) ? t : (op == 3'd7) ? 1'b0 : (rt ^ rn);
        end
        return {mkf(r, w, cf, of, 1'b0), r};
    endfunction

    function automatic logic [21:0] m_var(input logic [2:0] op, input logic w, input logic c,
                                          input logic [15:0] a, input int n);
        logic [21:0] st;
        st = {mkf(msk(a, w), w, c, 0, 0), msk(a, w)};
        for (int i = 0; i < n; i++) st = m_step(op, w, st[16], st[15:0]);
        return st;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive a single-cycle op now, sample 1 ns later
    task automatic do_comb(input string req, input logic sm, input logic [2:0] op, input logic w,
                           input logic sx, input logic c, input logic fo,
                           input logic [15:0] a, input logic [15:0] b);
        logic [21:0] e;
        logic ew;
        shift_mode = sm; op_sel = op; is_word = w; sx_imm = sx; carry_in = c;
        flags_only = fo; opa = a; opb = b;
        #1;
        e  = sm ? m_step(op, w, c, a) : m_arith(op, w, sx, c, a, b);
        ew = ~fo & (sm | (op != 3'd7));
        chk({req, " res"}, 32'(res), 32'(e[15:0]));
        chk({req, " flags"}, 32'(flags), 32'(e[21:16]));
        chk({req, " wr_en"}, 32'(wr_en), 32'(ew));
    endtask

    task automatic rnd_comb(input string req);
        do_comb(req, 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'(($urandom % 5) == 0), 16'($urandom), 16'($urandom));
    endtask

    task automatic var_run(input logic [2:0] op, input logic w, input logic c,
                           input logic [15:0] a, input int n, input bit inject);
        logic [21:0] e;
        int k;
        string tag;
        tag = (n == 0) ? "R10" : (inject ? "R11" : "R9");
        @(negedge clk);
        shift_mode = 1; op_sel = op; is_word = w; carry_in = c; opa = a;
        count = CW'(n); start = 1;
        k = 0;
        while (1) begin
            @(negedge clk);
            k++;
            if (k == 1 && inject) begin
                start = 1; opa = ~a; count = CW'(n + 3); op_sel = op ^ 3'd1;
                #1;
            end else begin
                start = 0;
                rnd_comb("R12");
            end
            if (var_done || k > n + 5) break;
            chk({tag, " busy"}, 32'(busy), 32'd1);
        end
        start = 0;
        e = m_var(op, w, c, a, n);
        chk({tag, " done cycle"}, 32'(k), 32'(n + 2));
        chk({tag, " var_res"}, 32'(var_res), 32'(e[15:0]));
        chk({tag, " var_flags"}, 32'(var_flags), 32'(e[21:16]));
        chk({tag, " busy at done"}, 32'(busy), 32'd0);
        @(negedge clk);
        chk({tag, " done pulse"}, 32'(var_done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 reset busy", 32'(busy), 0);
        chk("R9 reset done", 32'(var_done), 0);
        chk("R9 reset var_res", 32'(var_res), 0);

        // directed corners
        do_comb("R4", 0, 3'd0, 1, 1, 0, 0, 16'h0001, 16'h12FF);
        chk("R4 ext FF", 32'(res), 32'h0000);
        do_comb("R5", 0, 3'd0, 0, 0, 0, 0, 16'hAB80, 16'hCD80);
        chk("R5 byte cf/of", 32'({flags[5], flags[0]}), 32'b11);
        do_comb("R8", 1, 3'd6, 0, 0, 0, 0, 16'h1234, 0);
        chk("R8 byte ones", 32'(res), 32'h00FF);
        do_comb("R8", 1, 3'd6, 1, 0, 1, 0, 16'h0000, 0);
        chk("R8 word ones", 32'(res), 32'hFFFF);
        do_comb("R6", 0, 3'd7, 1, 0, 0, 0, 16'h0005, 16'h0005);
        chk("R6 cmp zf", 32'(flags[3]), 1);
        do_comb("R6", 0, 3'd4, 1, 0, 0, 1, 16'h00F0, 16'h0F0F);
        chk("R6 test wr", 32'(wr_en), 0);
        do_comb("R1", 0, 3'd3, 1, 0, 1, 0, 16'h0000, 16'h0000);
        chk("R1 sbb borrow", 32'(res), 32'hFFFF);
        do_comb("R2", 0, 3'd6, 1, 0, 1, 0, 16'hFFFF, 16'h7FFF);
        do_comb("R3", 0, 3'd0, 0, 0, 0, 0, 16'h000F, 16'h0001);
        chk("R3 af", 32'(flags[2]), 1);
        do_comb("R7", 1, 3'd3, 1, 0, 1, 0, 16'h0001, 0);
        chk("R7 rcr", 32'(res), 32'h8000);
        do_comb("R7", 1, 3'd7, 0, 0, 0, 0, 16'h0081, 0);
        chk("R7 sar byte", 32'(res), 32'h00C0);

        // random single-cycle
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rnd_comb("R1");
        end

        // variable shifts
        var_run(3'd4, 1, 0, 16'h1234, 0, 0);
        var_run(3'd2, 0, 1, 16'h0055, 9, 0);
        var_run(3'd7, 1, 0, 16'h8001, 5, 1);
        var_run(3'd3, 1, 1, 16'hA5A5, 17, 1);
        for (int i = 0; i < 40; i++)
            var_run(3'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                    int'($urandom % 21), 1'(i % 3 == 0 && i > 0));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule